// File: doc/BRIEF.md
# Switch Reset and PHY-Poller Sequencer

This block holds the global control and status logic of a small Ethernet switch. Software reaches it through a 16-bit register bus made of an address, a write enable, write data and combinational read data. A write to the control register can request a software reset and can turn the PHY polling unit on or off. The status register shows how far the switch has progressed: an init-ready flag and a two-bit poller state field.

A reset request starts a fixed sequence. The sequencer holds the reset phase, then initializes the internal units (address table, VLAN table and so on), and then, if polling is enabled, runs PHY detection before it settles into continuous polling. Real PHY management traffic is not modelled. A parameterized cycle count stands in for each phase. The control and status pins are plain level signals. The block has no streaming data path, so none of its ports uses a valid/ready handshake.

A build option selects a compact status format. In that format one bit reads 1 once polling is running.

Top module: `sw_reset_poll_seq`

## Requirements
- R1: After hardware reset the poller state code is 00 and init ready is 1. A status read returns 0x0800 and a control read returns 0x0000.
- R2: When no reset is in progress, writing the control register with bit 15 set starts a reset on that clock edge. Control bit 15 then reads 1 for exactly RST_CYCLES cycles and clears by itself.
- R3: Init ready, which is status bit 11 and output `init_ready_o`, reads 0 for RST_CYCLES+INIT_CYCLES cycles from the reset write and then returns to 1. During the reset phase the state code is 00, and during initialization it is 01.
- R4: If the enable bit (control bit 14) is 1 when initialization ends, the state code reads 10 for DET_CYCLES cycles and then 11.
- R5: When the block is idle, writing enable=1 without reset moves the state code to 10 from the second edge after the write. The code reads 11 after DET_CYCLES more cycles.
- R6: Writing enable=0 while the state code is 10 or 11 returns the code to 00 from the second edge after the write.
- R7: While a reset or initialization is in progress (init ready 0), every control write is ignored. This covers the enable bit, bits 13:0 and a repeated reset bit.
- R8: Control bits 13:0 are stored and read back unchanged. Status bits 13:12 and 10:0 read 0. Writes to any address other than CONTROL_ADDR change nothing, and reads of unmapped addresses return 0.
- R9: A reset write made while polling restarts the whole sequence from the reset phase.
- R10: In the compact status variant, status bit 15 reads 1 exactly when the poller is polling, and bit 14 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write enable, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| poll_state_o | output | 2 | Poller state code: 00 off or reset, 01 init, 10 detect, 11 polling |
| init_ready_o | output | 1 | 1 when no reset or initialization is in progress |

## Verification
The hardest situations to reach from the ports are the writes that land inside the short reset and initialization windows. Such a write must leave no trace, even when it carries a second reset request or a cleared enable bit. The stimulus counts edges from its own reset write and places writes in each window. It then watches whether the later detect phase still starts. A second pattern clears the enable bit while detection is still running, before polling begins. A behavioural model of the phase timing in the bench is compared with the state code, init ready and read data of both status variants on every clock.

// File: rtl/sw_seq_pkg.sv
package sw_seq_pkg;
  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_RST  = 3'd1,
    PH_INIT = 3'd2,
    PH_DET  = 3'd3,
    PH_POLL = 3'd4
  } phase_e;

  localparam int CTL_RST_BIT = 15;
  localparam int CTL_EN_BIT  = 14;
  localparam int STS_RDY_BIT = 11;
  localparam int REG_W       = 16;

  function automatic logic [1:0] phase_code(phase_e p);
    case (p)
      PH_INIT: return 2'b01;
      PH_DET:  return 2'b10;
      PH_POLL: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sw_seq_timer.sv
module sw_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3: once loaded the counter only counts down toward zero
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sw_seq_fsm.sv
module sw_seq_fsm
  import sw_seq_pkg::*;
#(
  parameter int RST_CYCLES  = 4,
  parameter int INIT_CYCLES = 16,
  parameter int DET_CYCLES  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rst_start,
  input  logic   poll_en,
  output phase_e phase_o,
  output logic   busy_o
);
  localparam int MAX_C = max3(RST_CYCLES, INIT_CYCLES, DET_CYCLES);
  localparam int CNT_W = $clog2(MAX_C + 1);

  phase_e           phase_q, phase_d;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  sw_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    if (rst_start) begin
      phase_d = PH_RST;
      t_load  = 1'b1;
      t_val   = CNT_W'(RST_CYCLES - 1);
    end else begin
      case (phase_q)
        PH_RST: if (t_zero) begin
          phase_d = PH_INIT;
          t_load  = 1'b1;
          t_val   = CNT_W'(INIT_CYCLES - 1);
        end
        PH_INIT: if (t_zero) begin
          if (poll_en) begin
            phase_d = PH_DET;
            t_load  = 1'b1;
            t_val   = CNT_W'(DET_CYCLES - 1);
          end else begin
            phase_d = PH_OFF;
          end
        end
        PH_OFF: if (poll_en) begin
          phase_d = PH_DET;
          t_load  = 1'b1;
          t_val   = CNT_W'(DET_CYCLES - 1);
        end
        PH_DET: begin
          if (!poll_en)    phase_d = PH_OFF;
          else if (t_zero) phase_d = PH_POLL;
        end
        PH_POLL: if (!poll_en) phase_d = PH_OFF;
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_OFF;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q == PH_RST) || (phase_q == PH_INIT);

  // R3: init ready can only drop because a reset request was accepted
  assert_rdy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(rst_start));

  // R2: leaving the reset phase always leads into initialization
  assert_rst_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_RST && $past(phase_q) == PH_RST) |-> phase_q == PH_INIT);

  // R4: polling is only entered from detection
  assert_poll_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_POLL && $past(phase_q) != PH_POLL) |-> $past(phase_q) == PH_DET);

  // R6: a cleared enable drops detection or polling on the next edge
  assert_disable_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_en && (phase_q == PH_DET || phase_q == PH_POLL))
      |=> (phase_q == PH_OFF || phase_q == PH_RST));
endmodule

// File: rtl/sw_seq_regs.sv
module sw_seq_regs
  import sw_seq_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STATUS_ADDR  = 0,
  parameter int CONTROL_ADDR = 4,
  parameter bit COMPACT      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  phase_e            phase,
  input  logic              busy,
  output logic              rst_start,
  output logic              poll_en
);
  logic [REG_W-2:0] ctl_q;
  logic [REG_W-1:0] sts_word;
  logic             accept;

  assign accept    = we && (addr == ADDR_W'(CONTROL_ADDR)) && !busy;
  assign rst_start = accept && wdata[CTL_RST_BIT];
  assign poll_en   = ctl_q[CTL_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (accept) ctl_q <= wdata[REG_W-2:0];
  end

  generate
    if (COMPACT) begin : g_compact
      assign sts_word = {phase == PH_POLL, 1'b0, 2'b00, !busy, 11'd0};
    end else begin : g_full
      assign sts_word = {phase_code(phase), 2'b00, !busy, 11'd0};
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(STATUS_ADDR))       rdata = sts_word;
    else if (addr == ADDR_W'(CONTROL_ADDR)) rdata = {phase == PH_RST, ctl_q};
  end

  // R7: stored control bits stay put while a reset or init is running
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));

  // R8: writes to other addresses leave the control bits alone
  assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != ADDR_W'(CONTROL_ADDR)) |=> $stable(ctl_q));
endmodule

// File: rtl/sw_reset_poll_seq.sv
module sw_reset_poll_seq
  import sw_seq_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STATUS_ADDR  = 0,
  parameter int CONTROL_ADDR = 4,
  parameter int RST_CYCLES   = 4,
  parameter int INIT_CYCLES  = 16,
  parameter int DET_CYCLES   = 8,
  parameter bit COMPACT      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [1:0]        poll_state_o,
  output logic              init_ready_o
);
  phase_e phase;
  logic   busy, rst_start, poll_en;

  sw_seq_regs #(
    .ADDR_W       (ADDR_W),
    .STATUS_ADDR  (STATUS_ADDR),
    .CONTROL_ADDR (CONTROL_ADDR),
    .COMPACT      (COMPACT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .we        (reg_we),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .phase     (phase),
    .busy      (busy),
    .rst_start (rst_start),
    .poll_en   (poll_en)
  );

  sw_seq_fsm #(
    .RST_CYCLES  (RST_CYCLES),
    .INIT_CYCLES (INIT_CYCLES),
    .DET_CYCLES  (DET_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_start (rst_start),
    .poll_en   (poll_en),
    .phase_o   (phase),
    .busy_o    (busy)
  );

  assign poll_state_o = phase_code(phase);
  assign init_ready_o = !busy;
endmodule

// File: tb/sw_reset_poll_seq_tb.sv
module sw_reset_poll_seq_tb;
  localparam int AW = 4, STA = 0, CTA = 4, RC = 3, IC = 5, DC = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata, rdata_c;
  logic [1:0]    pst, pst_c;
  logic          rdy, rdy_c;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sw_reset_poll_seq #(.ADDR_W(AW), .STATUS_ADDR(STA), .CONTROL_ADDR(CTA),
    .RST_CYCLES(RC), .INIT_CYCLES(IC), .DET_CYCLES(DC), .COMPACT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .poll_state_o(pst), .init_ready_o(rdy));

  sw_reset_poll_seq #(.ADDR_W(AW), .STATUS_ADDR(STA), .CONTROL_ADDR(CTA),
    .RST_CYCLES(RC), .INIT_CYCLES(IC), .DET_CYCLES(DC), .COMPACT(1'b1)) u_dut_compact (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata_c), .poll_state_o(pst_c), .init_ready_o(rdy_c));

  // behavioural model: 0 off, 1 reset, 2 init, 3 detect, 4 poll
  int m_ph = 0, m_left = 0;
  bit m_en = 0;
  logic [14:0] m_ctl = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_en = 0; m_ctl = '0;
    end else begin
      bit busy, acc;
      busy = (m_ph == 1 || m_ph == 2);
      acc  = we && addr == AW'(CTA) && !busy;
      if (acc && wdata[15]) begin
        m_ph = 1; m_left = RC;
      end else begin
        case (m_ph)
          1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = IC; end end
          2: begin m_left--; if (m_left == 0) begin
               if (m_en) begin m_ph = 3; m_left = DC; end else m_ph = 0;
             end end
          0: if (m_en) begin m_ph = 3; m_left = DC; end
          3: if (!m_en) m_ph = 0;
             else begin m_left--; if (m_left == 0) m_ph = 4; end
          default: if (!m_en) m_ph = 0;
        endcase
      end
      if (acc) begin m_ctl = wdata[14:0]; m_en = m_ctl[14]; end
    end
  end

  function automatic int exp_code();
    case (m_ph) 2: return 1; 3: return 2; 4: return 3; default: return 0; endcase
  endfunction

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      int er, erc;
      bit xr;
      xr = !(m_ph == 1 || m_ph == 2);
      check("state code", pst, exp_code());
      check("init ready", rdy, xr);
      if (addr == AW'(STA)) begin
        er  = (exp_code() << 14) | (xr << 11);
        erc = ((m_ph == 4) << 15) | (xr << 11);
      end else if (addr == AW'(CTA)) begin
        er  = ((m_ph == 1) << 15) | m_ctl;
        erc = er;
      end else begin
        er = 0; erc = 0;
      end
      check("read data", rdata, er);
      check("compact read data", rdata_c, erc);
    end
  end

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = AW'(STA);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(int a, int n);
    @(negedge clk); addr = AW'(a);
    repeat (n) @(negedge clk);
    addr = AW'(STA);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(2);
    @(negedge clk); // explicit reset-state checks at the ports
    check("reset status", rdata, 16'h0800);
    check("reset code", pst, 0);
    look(CTA, 2);
    cur_req = "R8";
    wr(CTA, 16'h1234);
    look(CTA, 2);
    wr(2, 16'hFFFF);
    look(2, 2);
    look(CTA, 1);
    cur_req = "R5";
    wr(CTA, 16'h4011);
    idle(DC + 3);
    cur_req = "R10";
    idle(3);
    cur_req = "R6";
    wr(CTA, 16'h0011);
    idle(3);
    cur_req = "R5";
    wr(CTA, 16'h4000);
    idle(2);
    cur_req = "R6";
    wr(CTA, 16'h0000);
    idle(3);
    cur_req = "R2";
    wr(CTA, 16'h8000);
    look(CTA, RC + 1);
    cur_req = "R3";
    idle(IC + 2);
    cur_req = "R7";
    wr(CTA, 16'hC000);
    wr(CTA, 16'h0055);
    idle(RC);
    wr(CTA, 16'h8000);
    look(CTA, 2);
    cur_req = "R4";
    idle(IC + DC + 3);
    cur_req = "R9";
    wr(CTA, 16'hC000);
    idle(RC + IC + DC + 4);
    cur_req = "R10";
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule